// File: doc/BRIEF.md
# Frequency Lock Monitor

This block watches a recovered oscillator clock and judges, once per measurement window, whether its frequency sits close enough to a local reference. A window lasts a fixed number of reference cycles, `2**WIN_LOG2`. Over that window the block counts oscillator edges and compares the count with the nominal value, `VCO_PER_REF` oscillator cycles for each reference cycle. The allowed deviation takes one of two values, chosen by an input. The narrow setting suits a tight ppm window and the wide setting one about four times looser.

The oscillator count runs freely in its own clock domain. It crosses into the reference domain as a Gray code through a two-stage synchroniser. At each window boundary the block takes the difference between the current snapshot and the previous one.

A state machine turns each window verdict into three outputs:

- a lock flag;
- a kick-back pulse, which tells the loop to pull the oscillator back onto the reference;
- a loss-of-data indicator.

The states are SETTLE, HUNT, CONFIRM, LOCKED and KICK. Reset enters SETTLE, where the first window only primes the baseline snapshot. The transitions are:

- SETTLE to HUNT at the window end, with the verdict ignored.
- HUNT to CONFIRM on an in-tolerance verdict, and HUNT to KICK on an out-of-tolerance verdict.
- CONFIRM to LOCKED on an in-tolerance verdict, and CONFIRM to KICK on an out-of-tolerance verdict.
- LOCKED stays in LOCKED on an in-tolerance verdict and goes to KICK on an out-of-tolerance verdict.
- KICK to SETTLE at the window end.

After a kick the loop always settles for one window and then hunts again, so acquisition never stops.

Top module: `freq_lock_monitor`

## Requirements
- R1: While reset is asserted, locked, kick and data_lost are all low. The first window after reset release yields no verdict, so even with a correct frequency, locked stays low through the third window and rises only at the start of the fourth.
- R2: A verdict is formed once per window of `2**WIN_LOG2` reference cycles. It compares the oscillator cycles counted in that window against `VCO_PER_REF * 2**WIN_LOG2`.
- R3: A window is in tolerance when the absolute deviation of its count is no larger than the threshold. With wide_tol = 0 the threshold is TOL_NARROW counts, and with wide_tol = 1 it is TOL_WIDE counts. wide_tol is sampled at the window end.
- R4: locked rises only after two consecutive in-tolerance verdicts that are taken in HUNT and CONFIRM. It rises one reference cycle after the second of those window ends.
- R5: An out-of-tolerance verdict while locked clears locked and raises kick in the same reference cycle. locked and kick are never high together.
- R6: kick, once raised, stays high for exactly `2**WIN_LOG2` reference cycles, which is one full window.
- R7: The window that follows a kick is a settle window. Its verdict is ignored, and no kick and no lock can come from it.
- R8: data_lost rises on an out-of-tolerance verdict and stays high until the next in-tolerance verdict taken in HUNT, CONFIRM or LOCKED. It is high whenever kick rises.
- R9: Acquisition never stops. After each settle window the block hunts again, kicks again if the frequency is still out of tolerance, and locks again once the frequency returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; all decisions are made in this domain |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| vco_clk | input | 1 | Recovered oscillator clock whose frequency is measured |
| wide_tol | input | 1 | Tolerance select: 0 is the narrow threshold, 1 the wide one |
| locked | output | 1 | High while the oscillator is judged locked to the reference |
| kick | output | 1 | One-window pulse asking the loop to return to the reference |
| data_lost | output | 1 | High from an out-of-tolerance verdict until the next in-tolerance verdict |

## Verification
The two functions that share a cycle are the lock drop and the start of the kick pulse. One out-of-tolerance verdict taken in LOCKED must clear locked in the very cycle that kick rises. The bench provokes this three ways by shortening the oscillator period while locked:

- once beyond only the narrow threshold;
- once beyond both thresholds;
- once with a frequency the wide setting accepts and the narrow setting rejects, after wide_tol is switched back to narrow.

The bench samples every window twice and compares the output triple with the scoreboard. It also measures each kick pulse against the window length.

// File: rtl/flm_pkg.sv
package flm_pkg;

    typedef enum logic [2:0] {
        ST_SETTLE  = 3'd0,
        ST_HUNT    = 3'd1,
        ST_CONFIRM = 3'd2,
        ST_LOCKED  = 3'd3,
        ST_KICK    = 3'd4
    } flm_state_t;

    typedef struct packed {
        logic valid;
        logic in_tol;
    } flm_verdict_t;

endpackage

// File: rtl/flm_vco_counter.sv
module flm_vco_counter #(
    parameter int CW = 18
) (
    input  logic          vco_clk,
    input  logic          rst_n,
    output logic [CW-1:0] gray_q
);

    logic [CW-1:0] bin_q;
    logic [CW-1:0] bin_nx;

    always_comb begin
        bin_nx = bin_q + 1'b1;
    end

    // The Gray register is loaded from the next binary value, so it moves
    // by one bit per oscillator cycle.
    always_ff @(posedge vco_clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_nx;
            gray_q <= bin_nx ^ (bin_nx >> 1);
        end
    end

endmodule

// File: rtl/flm_gray_sync.sv
module flm_gray_sync #(
    parameter int CW     = 18,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] gray_in,
    output logic [CW-1:0] bin_out
);

    logic [CW-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= gray_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    // Gray to binary: each bit is the XOR of all Gray bits at or above it.
    always_comb begin
        bin_out[CW-1] = stage_q[STAGES-1][CW-1];
        for (int i = CW - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ stage_q[STAGES-1][i];
        end
    end

endmodule

// File: rtl/flm_window.sv
module flm_window
    import flm_pkg::*;
#(
    parameter int WIN_LOG2    = 16,
    parameter int VCO_PER_REF = 2,
    parameter int CW          = 19,
    parameter int TOL_NARROW  = 33,
    parameter int TOL_WIDE    = 131
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide_tol,
    input  logic [CW-1:0] vco_bin,
    output logic          win_end,
    output flm_verdict_t  verdict
);

    localparam int             EXP_COUNT = VCO_PER_REF << WIN_LOG2;
    localparam int             DW        = CW + 2;
    localparam logic [DW-1:0]  EXP_U     = EXP_COUNT[DW-1:0];
    localparam logic [DW-1:0]  THR_N     = TOL_NARROW[DW-1:0];
    localparam logic [DW-1:0]  THR_W     = TOL_WIDE[DW-1:0];

    logic [WIN_LOG2-1:0] tick_q;
    logic [CW-1:0]       prev_q;
    logic                primed_q;
    logic [CW-1:0]       delta;
    logic [DW-1:0]       dev;
    logic [DW-1:0]       mag;
    logic [DW-1:0]       thr;

    assign win_end = &tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q   <= '0;
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            tick_q <= tick_q + 1'b1;
            if (win_end) begin
                prev_q   <= vco_bin;
                primed_q <= 1'b1;
            end
        end
    end

    // The modular difference of free-running snapshots gives the window count.
    always_comb begin
        delta = vco_bin - prev_q;
        dev   = {2'b00, delta} - EXP_U;
        mag   = dev[DW-1] ? (~dev + 1'b1) : dev;
        thr   = wide_tol ? THR_W : THR_N;
        verdict.valid  = win_end && primed_q;
        verdict.in_tol = (mag <= thr);
    end

endmodule

// File: rtl/freq_lock_monitor.sv
module freq_lock_monitor
    import flm_pkg::*;
#(
    parameter int WIN_LOG2    = 16,
    parameter int VCO_PER_REF = 2,
    parameter int TOL_NARROW  = 33,
    parameter int TOL_WIDE    = 131,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic vco_clk,
    input  logic wide_tol,
    output logic locked,
    output logic kick,
    output logic data_lost
);

    localparam int CW = WIN_LOG2 + $clog2(VCO_PER_REF) + 2;

    logic [CW-1:0] vco_gray;
    logic [CW-1:0] vco_bin;
    logic          win_end;
    flm_verdict_t  verdict;
    logic          vrd_valid;
    logic          vrd_in_tol;
    flm_state_t    state_q;
    flm_state_t    state_d;
    logic          lost_q;

    flm_vco_counter #(.CW(CW)) u_vco_cnt (
        .vco_clk (vco_clk),
        .rst_n   (rst_n),
        .gray_q  (vco_gray)
    );

    flm_gray_sync #(.CW(CW), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .gray_in (vco_gray),
        .bin_out (vco_bin)
    );

    flm_window #(
        .WIN_LOG2    (WIN_LOG2),
        .VCO_PER_REF (VCO_PER_REF),
        .CW          (CW),
        .TOL_NARROW  (TOL_NARROW),
        .TOL_WIDE    (TOL_WIDE)
    ) u_win (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .wide_tol (wide_tol),
        .vco_bin  (vco_bin),
        .win_end  (win_end),
        .verdict  (verdict)
    );

    assign vrd_valid  = verdict.valid;
    assign vrd_in_tol = verdict.in_tol;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SETTLE:  if (win_end) state_d = ST_HUNT;
            ST_HUNT:    if (vrd_valid) state_d = vrd_in_tol ? ST_CONFIRM : ST_KICK;
            ST_CONFIRM: if (vrd_valid) state_d = vrd_in_tol ? ST_LOCKED : ST_KICK;
            ST_LOCKED:  if (vrd_valid && !vrd_in_tol) state_d = ST_KICK;
            ST_KICK:    if (win_end) state_d = ST_SETTLE;
            default:    state_d = ST_SETTLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SETTLE;
        else        state_q <= state_d;
    end

    // Output register, loaded from the next state so it lines up with state_q.
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            locked <= 1'b0;
            kick   <= 1'b0;
            lost_q <= 1'b0;
        end else begin
            locked <= (state_d == ST_LOCKED);
            kick   <= (state_d == ST_KICK);
            if (vrd_valid && (state_q == ST_HUNT || state_q == ST_CONFIRM ||
                              state_q == ST_LOCKED)) begin
                lost_q <= !vrd_in_tol;
            end
        end
    end

    assign data_lost = lost_q;

endmodule

// File: rtl/flm_checker.sv
module flm_checker #(
    parameter int WIN_LOG2 = 16
) (
    input logic clk_ref,
    input logic rst_n,
    input logic locked,
    input logic kick,
    input logic data_lost,
    input logic vrd_valid,
    input logic vrd_in_tol
);

    localparam int                KW  = WIN_LOG2 + 2;
    localparam logic [KW-1:0]     WIN = KW'(1) << WIN_LOG2;

    logic [KW-1:0] kick_run;

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n)    kick_run <= '0;
        else if (kick) kick_run <= kick_run + 1'b1;
        else           kick_run <= '0;
    end

    // R5
    lock_kick_excl_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !(locked && kick));

    // R5
    lock_drop_kick_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $fell(locked) |-> $rose(kick));

    // R6
    kick_len_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $fell(kick) |-> (kick_run == WIN));

    // R8
    kick_lost_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(kick) |-> data_lost);

    // R4
    lock_rise_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(locked) |-> $past(vrd_valid && vrd_in_tol));

    // R7
    kick_cause_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(kick) |-> $past(vrd_valid && !vrd_in_tol));

endmodule

bind freq_lock_monitor flm_checker #(.WIN_LOG2(WIN_LOG2)) u_chk (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .locked     (locked),
    .kick       (kick),
    .data_lost  (data_lost),
    .vrd_valid  (vrd_valid),
    .vrd_in_tol (vrd_in_tol)
);

// File: tb/tb_freq_lock_monitor.sv
module tb_freq_lock_monitor;

    localparam int WL   = 10;
    localparam int W    = 1 << WL;
    localparam int TN   = 50;
    localparam int TW   = 200;
    localparam int NWIN = 21;

    typedef struct packed {
        logic lk;
        logic kk;
        logic ls;
    } exp_t;

    logic clk_ref = 1'b0;
    logic vco_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic wide_tol = 1'b0;
    logic locked, kick, data_lost;
    int   vco_half = 10;

    int   errors = 0;
    int   checks = 0;
    bit   done   = 1'b0;
    exp_t sb_q[$];

    freq_lock_monitor #(
        .WIN_LOG2    (WL),
        .VCO_PER_REF (1),
        .TOL_NARROW  (TN),
        .TOL_WIDE    (TW)
    ) dut (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .vco_clk   (vco_clk),
        .wide_tol  (wide_tol),
        .locked    (locked),
        .kick      (kick),
        .data_lost (data_lost)
    );

    // 50 MHz reference.
    initial forever #10 clk_ref = ~clk_ref;
    initial forever #(vco_half) vco_clk = ~vco_clk;

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic check_triple(input string req, input int win, input exp_t e);
        exp_t a;
        a = '{lk: locked, kk: kick, ls: data_lost};
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s window %0d: locked/kick/lost actual=%b expected=%b",
                     req, win, a, e);
        end
    endtask

    // Stimulus per window: oscillator half period, tolerance select, and the
    // outputs expected during that window (set by the previous verdict).
    // Half 10 = nominal, 9 = deviation near 114 counts, 8 = near 256 counts.
    function automatic int half_of(input int w);
        if (w >= 4 && w <= 8)   return 9;
        if (w >= 9 && w <= 12)  return 8;
        if (w >= 18 && w <= 19) return 9;
        return 10;
    endfunction

    function automatic logic tol_of(input int w);
        return (w >= 7 && w <= 12) || (w == 18);
    endfunction

    function automatic exp_t exp_of(input int w);
        case (w)
            3, 4, 9, 17, 18, 19: return '{lk: 1'b1, kk: 1'b0, ls: 1'b0};
            5, 10, 13, 20:       return '{lk: 1'b0, kk: 1'b1, ls: 1'b1};
            6, 7, 11, 12, 14, 15: return '{lk: 1'b0, kk: 1'b0, ls: 1'b1};
            default:             return '{lk: 1'b0, kk: 1'b0, ls: 1'b0};
        endcase
    endfunction

    // Driver: pushes the expected item and sets the stimulus per window.
    task automatic driver();
        for (int w = 0; w < NWIN; w++) begin
            sb_q.push_back(exp_of(w));
            vco_half = half_of(w);
            wide_tol = tol_of(w);
            repeat (W) @(posedge clk_ref);
            @(negedge clk_ref);
        end
    endtask

    function automatic string req_of(input int w);
        if (w <= 3)              return "R1/R4";
        if (w == 5 || w == 10)   return "R3/R5";
        if (w == 13 || w == 14)  return "R7/R9";
        if (w == 7 || w == 8)    return "R3/R8";
        if (w == 19 || w == 20)  return "R2/R3/R5";
        return "R8/R9";
    endfunction

    // Monitor: pops one item per window and checks it twice in that window.
    task automatic monitor();
        exp_t e;
        for (int w = 0; w < NWIN; w++) begin
            repeat (W / 4) @(posedge clk_ref);
            @(negedge clk_ref);
            if (sb_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R2 window %0d: scoreboard empty actual=0 expected=1", w);
                e = '0;
            end else begin
                e = sb_q.pop_front();
            end
            check_triple(req_of(w), w, e);
            repeat (W / 2) @(posedge clk_ref);
            @(negedge clk_ref);
            check_triple(req_of(w), w, e);
            repeat (W / 4) @(posedge clk_ref);
        end
    endtask

    // R6: each kick pulse lasts exactly one window.
    initial begin
        int   run = 0;
        logic prev = 1'b0;
        forever begin
            @(negedge clk_ref);
            if (rst_n) begin
                if (kick) run++;
                if (prev && !kick) begin
                    checks++;
                    if (run != W) begin
                        errors++;
                        $display("FAIL R6 kick length actual=%0d expected=%0d", run, W);
                    end
                    run = 0;
                end
                prev = kick;
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk_ref);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung actual=running expected=finished");
            report();
        end
    end

    initial begin
        repeat (5) @(negedge clk_ref);
        // R1: reset state.
        check_triple("R1", -1, '0);
        rst_n = 1'b1;
        fork
            driver();
            monitor();
        join
        // Final window kick must end exactly one window later (R6 counter).
        repeat (W + 4) @(posedge clk_ref);
        @(negedge clk_ref);
        check_triple("R6/R9", NWIN, '{lk: 1'b0, kk: 1'b0, ls: 1'b1});
        done = 1'b1;
        report();
    end

endmodule